// File: doc/BRIEF.md
# Single-Cycle Load/Store RISC Core

This block is a 32-bit processor core that retires one instruction on every clock edge. It executes an eight-instruction subset: word load, word store, branch-on-equal, and the register-register operations add, subtract, AND, OR and signed set-on-less-than. Each instruction is fetched, decoded, executed and written back inside a single cycle. A dedicated incrementer and a separate branch-target adder keep the ALU free for the operation itself.

Program and data live in two small internal word arrays. Both can be filled through a loader port while reset is held. A peek port reads the data array, and a commit port shows the register write and the memory store that the current instruction will perform on the next edge. Together these let a bench follow execution cycle by cycle without reaching inside the core.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` drives the PC to 0 on the next rising edge. While `rst` is high, no register or data-memory write occurs, and `wb_en` and `st_en` read 0. Loader writes are honoured only while `rst` is high.
- R2: Opcode 0 selects a register operation on rs [25:21] and rt [20:16], with the result written to rd [15:11]. The funct field [5:0] selects the operation: 0x20 add, 0x22 subtract (rs minus rt), 0x24 AND, 0x25 OR.
- R3: Funct 0x2A writes 1 when rs is less than rt as signed 32-bit numbers, and 0 otherwise.
- R4: Opcode 35 loads the data word at byte address rs + sign-extended imm [15:0] into register rt. Memories are word-addressed by address bits [31:2].
- R5: Opcode 43 stores register rt at byte address rs + sign-extended imm. It performs no register write.
- R6: Opcode 4 compares rs with rt. If they are equal, the next PC is PC+4 + (sign-extended imm shifted left by 2); otherwise it is PC+4. A branch writes neither registers nor memory.
- R7: Register 0 always reads as zero, and a write to it has no effect.
- R8: Any opcode other than 0, 4, 35 or 43 writes nothing and advances the PC by 4.
- R9: An instruction reads its source registers as they were before the edge on which it writes. A register written on one edge is seen by the next instruction.
- R10: Every non-branch instruction advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Loader write strobe (honoured only during reset) |
| ld_dmem | input | 1 | Loader target: 0 = program array, 1 = data array |
| ld_addr | input | 32 | Loader byte address (bits [31:2] select the word) |
| ld_data | input | 32 | Loader write word |
| peek_addr | input | 32 | Byte address for reading the data array |
| peek_data | output | 32 | Data array word at `peek_addr` |
| pc_o | output | 32 | Current program counter |
| wb_en | output | 1 | Register write happens on the coming edge |
| wb_reg | output | 5 | Destination register of that write |
| wb_val | output | 32 | Value being written |
| st_en | output | 1 | Data store happens on the coming edge |
| st_addr | output | 32 | Store byte address |
| st_val | output | 32 | Store data |

## Verification
Two things share a single edge: writing a result register and reading source operands that may name the same register. Writing the next PC and writing back also share that edge. The program includes `add r2,r2,r2` followed at once by a store of r2. The add must double the old value, not its own result, and the store must carry the doubled value. The taken backward branch and a write to register 0 are judged the same way at the commit port. The check is then repeated afterwards through the peek port.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int REG_W = 5;

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10,
    CLS_RSVD  = 2'b11
  } op_class_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_sel_e;

  typedef struct packed {
    logic      dst_is_rd;
    logic      b_is_imm;
    logic      wb_from_mem;
    logic      reg_wr;
    logic      mem_wr;
    logic      is_branch;
    op_class_e op_class;
  } ctrl_t;
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{dst_is_rd: 1'b0, b_is_imm: 1'b0, wb_from_mem: 1'b0, reg_wr: 1'b0,
             mem_wr: 1'b0, is_branch: 1'b0, op_class: CLS_ADD};
    case (opcode)
      OPC_REG: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_wr    = 1'b1;
        ctrl.op_class  = CLS_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_wr      = 1'b1;
      end
      OPC_STORE: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.mem_wr   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.op_class  = CLS_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu_ctl.sv
module sc_alu_ctl
  import sc_pkg::*;
(
  input  op_class_e op_class,
  input  logic [5:0] funct,
  output alu_sel_e   sel
);
  always_comb begin
    case (op_class)
      CLS_ADD: sel = ALU_ADD;
      CLS_SUB: sel = ALU_SUB;
      CLS_FUNCT: begin
        case (funct)
          FN_ADD:  sel = ALU_ADD;
          FN_SUB:  sel = ALU_SUB;
          FN_AND:  sel = ALU_AND;
          FN_OR:   sel = ALU_OR;
          FN_SLT:  sel = ALU_SLT;
          default: sel = ALU_ADD;
        endcase
      end
      default: sel = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_sel_e     sel,
  output logic [W-1:0] y,
  output logic         zero
);
  logic [W-1:0] diff;
  logic         lt;

  assign diff = a - b;
  assign lt   = (a[W-1] ^ b[W-1]) ? a[W-1] : diff[W-1];

  always_comb begin
    case (sel)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, lt};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  localparam int N = 1 << AW;

  logic [W-1:0] regs [1:N-1];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld_we,
  input  logic        ld_dmem,
  input  logic [31:0] ld_addr,
  input  logic [31:0] ld_data,
  input  logic [31:0] peek_addr,
  output logic [31:0] peek_data,
  output logic [31:0] pc_o,
  output logic        wb_en,
  output logic [4:0]  wb_reg,
  output logic [31:0] wb_val,
  output logic        st_en,
  output logic [31:0] st_addr,
  output logic [31:0] st_val
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc_q, pc_plus4, br_target, pc_next;
  logic [XLEN-1:0] instr, imm_ext, imm_sh;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, mem_rd, wb_data;
  logic [REG_W-1:0] rs_a, rt_a, rd_a, dst_a;
  logic            alu_zero, take_br;
  ctrl_t           ctrl;
  alu_sel_e        alu_sel;

  logic            rf_we, dm_we;
  logic [DAW-1:0]  dm_idx;
  logic [XLEN-1:0] dm_wd;

  // fetch
  always_ff @(posedge clk) begin
    if (rst && ld_we && !ld_dmem) imem[ld_addr[IAW+1:2]] <= ld_data;
  end
  assign instr = imem[pc_q[IAW+1:2]];

  // field split
  assign rs_a    = instr[25:21];
  assign rt_a    = instr[20:16];
  assign rd_a    = instr[15:11];
  assign imm_ext = {{16{instr[15]}}, instr[15:0]};
  assign imm_sh  = {imm_ext[XLEN-3:0], 2'b00};

  sc_main_dec u_dec (
    .opcode (instr[31:26]),
    .ctrl   (ctrl)
  );

  sc_alu_ctl u_actl (
    .op_class (ctrl.op_class),
    .funct    (instr[5:0]),
    .sel      (alu_sel)
  );

  sc_regfile #(.W(XLEN), .AW(REG_W)) u_rf (
    .clk (clk),
    .we  (rf_we),
    .wa  (dst_a),
    .wd  (wb_data),
    .ra1 (rs_a),
    .ra2 (rt_a),
    .rd1 (rs_val),
    .rd2 (rt_val)
  );

  assign alu_b = ctrl.b_is_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .sel  (alu_sel),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: loader port during reset, store port otherwise
  assign mem_rd = dmem[alu_y[DAW+1:2]];
  always_comb begin
    if (rst) begin
      dm_we  = ld_we && ld_dmem;
      dm_idx = ld_addr[DAW+1:2];
      dm_wd  = ld_data;
    end else begin
      dm_we  = ctrl.mem_wr;
      dm_idx = alu_y[DAW+1:2];
      dm_wd  = rt_val;
    end
  end
  always_ff @(posedge clk) begin
    if (dm_we) dmem[dm_idx] <= dm_wd;
  end
  assign peek_data = dmem[peek_addr[DAW+1:2]];

  // writeback
  assign dst_a   = ctrl.dst_is_rd ? rd_a : rt_a;
  assign wb_data = ctrl.wb_from_mem ? mem_rd : alu_y;
  assign rf_we   = ctrl.reg_wr && !rst;

  // next PC: two dedicated adders
  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + imm_sh;
  assign take_br   = ctrl.is_branch && alu_zero;
  assign pc_next   = take_br ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_o    = pc_q;
  assign wb_en   = rf_we;
  assign wb_reg  = dst_a;
  assign wb_val  = wb_data;
  assign st_en   = ctrl.mem_wr && !rst;
  assign st_addr = alu_y;
  assign st_val  = rt_val;

  // checks
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> (!wb_en && !st_en)); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    !take_br |=> (pc_q == $past(pc_q) + 32'd4)); // R10
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    take_br |=> (pc_q == $past(br_target))); // R6
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    st_en |-> !wb_en); // R5
  AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == OPC_BEQ) |-> (!wb_en && !st_en)); // R6
  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (st_en && (rt_a == '0)) |-> (st_val == '0)); // R7
  AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (rst)
    ((instr[31:26] != OPC_REG) && (instr[31:26] != OPC_BEQ) &&
     (instr[31:26] != OPC_LOAD) && (instr[31:26] != OPC_STORE))
    |-> (!wb_en && !st_en)); // R8
endmodule

// File: tb/sc_core_test.sv
module sc_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0;
  logic        ld_dmem = 1'b0;
  logic [31:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] peek_addr = '0;
  logic [31:0] peek_data, pc_o, wb_val, st_addr, st_val;
  logic        wb_en, st_en;
  logic [4:0]  wb_reg;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sc_core uut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
    .ld_data(ld_data), .peek_addr(peek_addr), .peek_data(peek_data), .pc_o(pc_o),
    .wb_en(wb_en), .wb_reg(wb_reg), .wb_val(wb_val), .st_en(st_en),
    .st_addr(st_addr), .st_val(st_val)
  );

  function automatic logic [31:0] rop(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] iop(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  localparam int NPROG = 21;
  localparam logic [31:0] PROG [NPROG] = '{
    iop(6'd35, 0, 1, 16'd0),       // 0  lw r1,0(r0)
    iop(6'd35, 0, 2, 16'd4),       // 1  lw r2,4(r0)
    rop(1, 2, 3, 6'h20),           // 2  add r3
    rop(1, 2, 4, 6'h22),           // 3  sub r4
    rop(1, 2, 5, 6'h24),           // 4  and r5
    rop(1, 2, 6, 6'h25),           // 5  or r6
    rop(4, 1, 7, 6'h2A),           // 6  slt r7 = (-2 < 5)
    rop(1, 4, 8, 6'h2A),           // 7  slt r8 = (5 < -2)
    iop(6'd35, 0, 9, 16'd8),       // 8  lw r9,8(r0)
    iop(6'd43, 0, 3, 16'd12),      // 9  sw r3,12(r0)
    iop(6'd4, 1, 2, 16'd5),        // 10 beq not taken
    iop(6'd4, 5, 1, 16'd2),        // 11 beq taken to 56
    rop(1, 2, 10, 6'h20),          // 12 skipped
    rop(1, 2, 10, 6'h20),          // 13 skipped
    rop(1, 2, 0, 6'h20),           // 14 add r0 (ignored)
    iop(6'd43, 0, 0, 16'd16),      // 15 sw r0,16(r0)
    {6'h3F, 26'd0},                // 16 unknown opcode
    iop(6'd35, 3, 11, 16'hFFF8),   // 17 lw r11,-8(r3)
    rop(2, 2, 2, 6'h20),           // 18 add r2,r2,r2
    iop(6'd43, 0, 2, 16'd20),      // 19 sw r2,20(r0)
    iop(6'd4, 0, 0, 16'hFFEB)      // 20 beq back to 0
  };

  typedef struct packed {
    logic [23:0] tag;
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic        mwe;
    logic [31:0] ma;
    logic [31:0] md;
    logic [31:0] npc;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VEC [NVEC] = '{
    '{"R4 ", 32'd0,  1'b1, 5'd1,  32'd5,        1'b0, 32'd0,  32'd0,  32'd4},
    '{"R4 ", 32'd4,  1'b1, 5'd2,  32'd7,        1'b0, 32'd0,  32'd0,  32'd8},
    '{"R2 ", 32'd8,  1'b1, 5'd3,  32'd12,       1'b0, 32'd0,  32'd0,  32'd12},
    '{"R2 ", 32'd12, 1'b1, 5'd4,  32'hFFFFFFFE, 1'b0, 32'd0,  32'd0,  32'd16},
    '{"R2 ", 32'd16, 1'b1, 5'd5,  32'd5,        1'b0, 32'd0,  32'd0,  32'd20},
    '{"R2 ", 32'd20, 1'b1, 5'd6,  32'd7,        1'b0, 32'd0,  32'd0,  32'd24},
    '{"R3 ", 32'd24, 1'b1, 5'd7,  32'd1,        1'b0, 32'd0,  32'd0,  32'd28},
    '{"R3 ", 32'd28, 1'b1, 5'd8,  32'd0,        1'b0, 32'd0,  32'd0,  32'd32},
    '{"R4 ", 32'd32, 1'b1, 5'd9,  32'hFFFFFFFD, 1'b0, 32'd0,  32'd0,  32'd36},
    '{"R5 ", 32'd36, 1'b0, 5'd0,  32'd0,        1'b1, 32'd12, 32'd12, 32'd40},
    '{"R6 ", 32'd40, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0,  32'd44},
    '{"R6 ", 32'd44, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0,  32'd56},
    '{"R7 ", 32'd56, 1'b1, 5'd0,  32'd12,       1'b0, 32'd0,  32'd0,  32'd60},
    '{"R7 ", 32'd60, 1'b0, 5'd0,  32'd0,        1'b1, 32'd16, 32'd0,  32'd64},
    '{"R8 ", 32'd64, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0,  32'd68},
    '{"R4 ", 32'd68, 1'b1, 5'd11, 32'd7,        1'b0, 32'd0,  32'd0,  32'd72},
    '{"R9 ", 32'd72, 1'b1, 5'd2,  32'd14,       1'b0, 32'd0,  32'd0,  32'd76},
    '{"R9 ", 32'd76, 1'b0, 5'd0,  32'd0,        1'b1, 32'd20, 32'd14, 32'd80},
    '{"R6 ", 32'd80, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0,  32'd0},
    '{"R10", 32'd0,  1'b1, 5'd1,  32'd5,        1'b0, 32'd0,  32'd0,  32'd4},
    '{"R10", 32'd4,  1'b1, 5'd2,  32'd7,        1'b0, 32'd0,  32'd0,  32'd8}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic sel, input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    ld_we = 1'b1; ld_dmem = sel; ld_addr = addr; ld_data = data;
    @(posedge clk);
    #1 ld_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    for (int i = 0; i < NPROG; i++) load(1'b0, 32'(i * 4), PROG[i]);
    load(1'b1, 32'd0, 32'd5);
    load(1'b1, 32'd4, 32'd7);
    load(1'b1, 32'd8, 32'hFFFFFFFD);
    load(1'b1, 32'd12, 32'hDEADBEEF);
    load(1'b1, 32'd16, 32'h11111111);
    load(1'b1, 32'd20, 32'h22222222);

    @(negedge clk);
    chk("R1 reset pc", pc_o, 32'd0);
    chk("R1 no wb in reset", {31'd0, wb_en}, 32'd0);
    chk("R1 no store in reset", {31'd0, st_en}, 32'd0);
    rst = 1'b0;
    #1;

    for (int i = 0; i < NVEC; i++) begin
      string t;
      t = $sformatf("%s step %0d", VEC[i].tag, i);
      chk({t, " pc"}, pc_o, VEC[i].pc);
      chk({t, " wb_en"}, {31'd0, wb_en}, {31'd0, VEC[i].we});
      if (VEC[i].we) begin
        chk({t, " wb_reg"}, {27'd0, wb_reg}, {27'd0, VEC[i].wa});
        chk({t, " wb_val"}, wb_val, VEC[i].wd);
      end
      chk({t, " st_en"}, {31'd0, st_en}, {31'd0, VEC[i].mwe});
      if (VEC[i].mwe) begin
        chk({t, " st_addr"}, st_addr, VEC[i].ma);
        chk({t, " st_val"}, st_val, VEC[i].md);
      end
      @(posedge clk);
      @(negedge clk);
      chk({t, " next pc"}, pc_o, VEC[i].npc);
    end

    // reset mid-run: no commit while held, PC back to 0
    rst = 1'b1;
    #1;
    chk("R1 wb blocked", {31'd0, wb_en}, 32'd0);
    chk("R1 store blocked", {31'd0, st_en}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R1 pc after reset", pc_o, 32'd0);

    // memory contents after the run
    peek_addr = 32'd12; #1 chk("R5 stored word", peek_data, 32'd12);
    peek_addr = 32'd16; #1 chk("R7 r0 stored as zero", peek_data, 32'd0);
    peek_addr = 32'd20; #1 chk("R9 doubled r2 stored", peek_data, 32'd14);
    peek_addr = 32'd0;  #1 chk("R4 load left memory intact", peek_data, 32'd5);
    peek_addr = 32'd8;  #1 chk("R8 no stray write", peek_data, 32'hFFFFFFFD);

    done = 1'b1;
    finish_run();
  end
endmodule